// File: doc/BRIEF.md
# Sync Clamp Pulse Generator

This block watches a horizontal sync input and fires one short clamp pulse for each sync pulse. The pulse can sit at the start of the active sync interval or at its end. A sync-polarity input says whether the sync is active-high or active-low. The start and end of a sync pulse are always taken relative to that active level, so "start" means the beginning of the active interval in both polarities. A third control input inverts the clamp output.

The sync input is asynchronous to the block clock. It passes through a two-stage synchronizer and is then converted to active-high form before edge detection. At the nominal 4 MHz clock, each pulse is held for two clock cycles. That gives a 0.5 µs pulse, inside the 0.5 to 0.75 µs window the video front end needs. The polarity bit comes from outside; this block does not detect polarity.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While reset is asserted and after reset until the first pulse, clampOut equals invertOut, which is the inactive level.
- R2: The input is synchronized through two flip-flops. A qualifying sync edge presented before clock edge k makes clampOut active after clock edge k+2.
- R3: With syncActiveLow=0 sync is active when syncIn is 1. With syncActiveLow=1 sync is active when syncIn is 0.
- R4: With trailSel=0 a pulse starts at the start of each active sync interval. The end of the interval starts nothing.
- R5: With trailSel=1 a pulse starts at the end of each active sync interval. The start of the interval starts nothing.
- R6: Each clamp pulse stays active for exactly PulseLen clock cycles (default 2, which is 0.5 µs at 4 MHz).
- R7: A qualifying edge that arrives while a pulse is active is ignored. It neither extends nor restarts the pulse.
- R8: invertOut=0 gives an active-high clamp (idle 0). invertOut=1 gives an active-low clamp (idle 1). Changing it takes effect at once on the output level.
- R9: For the first three clock edges after reset, while the synchronizer and the edge history fill, no edge is recognized. A sync level already present at reset therefore produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (nominally 4 MHz) |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Asynchronous horizontal sync input |
| syncActiveLow | input | 1 | 1: sync is active-low; 0: active-high |
| trailSel | input | 1 | 0: pulse at start of sync; 1: pulse at end of sync |
| invertOut | input | 1 | 1: clamp output is active-low |
| clampOut | output | 1 | Clamp pulse output |

## Verification
The bench targets four corner cases.

- Latency: it measures the exact cycle a pulse appears after an input edge. A synchronizer with one stage too many or too few shifts the pulse by a cycle.
- Back-to-back edges: it drives sync pulses one or two cycles apart. A design that retriggers produces stretched pulses; a design that drops its counter early produces shortened ones.
- Reset with sync already active: it resets with the sync input already at its active level, in both polarities. An edge detector whose history starts at zero then emits a spurious pulse after reset.
- All control combinations: it runs every combination of polarity, edge select and inversion. A polarity or edge-select mix-up shows up as pulses at the wrong end of the sync interval.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

  // Edge information from the datapath to the control
  typedef struct packed {
    logic armed;
    logic lead;
    logic trail;
  } edgeInfo_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic pulseOn;
  } ctlStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } clampState_t;

endpackage

// File: rtl/clamp_datapath.sv
module clamp_datapath
  import clamp_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic       syncActiveLow,
  input  logic       invertOut,
  input  ctlStrobe_t strobe,
  output edgeInfo_t  edges,
  output logic       clampOut
);

  localparam int WarmLen = SyncStages + 1;
  localparam int WarmW   = $clog2(WarmLen + 1);

  logic [SyncStages-1:0] chain;
  logic                  syncd;
  logic                  normLvl;
  logic                  prevNorm;
  logic [WarmW-1:0]      warmCnt;
  logic                  armed;

  // synchronizer chain
  generate
    for (genvar i = 0; i < SyncStages; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= syncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncd   = chain[SyncStages-1];
  assign normLvl = syncd ^ syncActiveLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevNorm <= 1'b0;
    else       prevNorm <= normLvl;
  end

  // warm-up: history is meaningful once the chain and prevNorm are loaded
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       warmCnt <= '0;
    else if (warmCnt != WarmW'(WarmLen)) warmCnt <= warmCnt + 1'b1;
  end

  assign armed = (warmCnt == WarmW'(WarmLen));

  always_comb begin
    edges.armed = armed;
    edges.lead  = armed &  normLvl & ~prevNorm;
    edges.trail = armed & ~normLvl &  prevNorm;
  end

  assign clampOut = strobe.pulseOn ^ invertOut;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({edges.lead, edges.trail})); // R3

  AST_QUIET_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !(edges.lead || edges.trail)); // R9

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pulseOn |-> (clampOut == invertOut)); // R8

endmodule

// File: rtl/clamp_control.sv
module clamp_control
  import clamp_pkg::*;
#(
  parameter int PulseLen = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trailSel,
  input  edgeInfo_t  edges,
  output ctlStrobe_t strobe
);

  localparam int CntW = (PulseLen > 1) ? $clog2(PulseLen) : 1;

  clampState_t     state;
  logic [CntW-1:0] remain;
  logic            trigger;

  assign trigger = trailSel ? edges.trail : edges.lead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else begin
      case (state)
        ST_IDLE: if (trigger) begin
          state  <= ST_HOLD;
          remain <= CntW'(PulseLen - 1);
        end
        ST_HOLD: begin
          if (remain == '0) state <= ST_IDLE;
          else              remain <= remain - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.pulseOn = (state == ST_HOLD);

  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && !strobe.pulseOn) |=> strobe.pulseOn); // R4

  AST_HOLD_WHILE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pulseOn && remain != '0) |=> strobe.pulseOn); // R7

  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.pulseOn) && (PulseLen > 1) |=> strobe.pulseOn); // R6

  AST_ONLY_FROM_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pulseOn && !trigger) |=> !strobe.pulseOn); // R5

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clamp_pkg::*;
#(
  parameter int PulseLen   = 2,
  parameter int SyncStages = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic syncIn,
  input  logic syncActiveLow,
  input  logic trailSel,
  input  logic invertOut,
  output logic clampOut
);

  edgeInfo_t  edges;
  ctlStrobe_t strobe;

  clamp_datapath #(.SyncStages(SyncStages)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .syncIn       (syncIn),
    .syncActiveLow(syncActiveLow),
    .invertOut    (invertOut),
    .strobe       (strobe),
    .edges        (edges),
    .clampOut     (clampOut)
  );

  clamp_control #(.PulseLen(PulseLen)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .trailSel(trailSel),
    .edges   (edges),
    .strobe  (strobe)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |-> (clampOut == invertOut)); // R1

endmodule

// File: tb/tb_clamp_pulse_gen.sv
`timescale 1ns/1ps
module tb_clamp_pulse_gen;

  localparam int PulseLen = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncIn = 1'b0;
  logic syncActiveLow = 1'b0;
  logic trailSel = 1'b0;
  logic invertOut = 1'b0;
  logic clampOut;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string tag = "R1";

  clamp_pulse_gen #(.PulseLen(PulseLen), .SyncStages(2)) dut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .syncActiveLow(syncActiveLow),
    .trailSel(trailSel), .invertOut(invertOut), .clampOut(clampOut)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  int  samples[$];
  bit  mActive;
  int  mRemain;

  always @(posedge clk) begin
    if (!rstN) begin
      samples.delete();
      mActive = 0;
      mRemain = 0;
    end else begin
      int n;
      bit trig;
      bit nowLvl, prevLvl;
      n = samples.size();
      trig = 0;
      if (n >= 3) begin
        nowLvl  = samples[n-2] ^ syncActiveLow;
        prevLvl = samples[n-3] ^ syncActiveLow;
        trig = trailSel ? (!nowLvl && prevLvl) : (nowLvl && !prevLvl);
      end
      if (mActive) begin
        mRemain--;
        if (mRemain == 0) mActive = 0;
      end else if (trig) begin
        mActive = 1;
        mRemain = PulseLen;
      end
      samples.push_back(int'(syncIn));
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: clampOut=%0d expected %0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    check(clampOut === (mActive ^ invertOut), tag, int'(clampOut), int'(mActive ^ invertOut));
  end

  // watchdog
  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic doReset(input bit pol, input bit trail, input bit inv, input bit idleActive);
    @(negedge clk);
    rstN = 1'b0;
    syncActiveLow = pol;
    trailSel = trail;
    invertOut = inv;
    syncIn = idleActive ^ pol;
    repeat (2) @(negedge clk);
    check(clampOut === inv, "R1", int'(clampOut), int'(inv));
    rstN = 1'b1;
  endtask

  task automatic syncPulse(input int width, input int gap);
    syncIn = ~syncActiveLow;
    repeat (width) @(negedge clk);
    syncIn = syncActiveLow;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    // R1 / R2 / R6: latency and width from an idle, active-high sync
    tag = "R2";
    doReset(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check(clampOut === 1'b0, "R1", int'(clampOut), 0);
    syncIn = 1'b1;
    @(negedge clk);
    check(clampOut === 1'b0, "R2", int'(clampOut), 0);
    @(negedge clk);
    check(clampOut === 1'b0, "R2", int'(clampOut), 0);
    @(negedge clk);
    check(clampOut === 1'b1, "R2", int'(clampOut), 1);
    @(negedge clk);
    check(clampOut === 1'b1, "R6", int'(clampOut), 1);
    @(negedge clk);
    check(clampOut === 1'b0, "R6", int'(clampOut), 0);
    repeat (4) @(negedge clk);
    tag = "R4";
    syncIn = 1'b0;
    repeat (8) @(negedge clk);
    check(clampOut === 1'b0, "R4", int'(clampOut), 0);

    // R9: sync already active across reset, both polarities
    tag = "R9";
    for (int p = 0; p < 2; p++) begin
      doReset(p[0], 1'b0, 1'b0, 1'b1);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        check(clampOut === 1'b0, "R9", int'(clampOut), 0);
      end
      syncIn = syncActiveLow;
      repeat (6) @(negedge clk);
    end

    // R3 / R4 / R5 / R8: all control combinations with varied widths
    for (int cfg = 0; cfg < 8; cfg++) begin
      tag = cfg[1] ? "R5" : "R4";
      doReset(cfg[0], cfg[1], cfg[2], 1'b0);
      repeat (4) @(negedge clk);
      tag = cfg[0] ? "R3" : tag;
      syncPulse(8, 10);
      syncPulse(1, 6);
      syncPulse(3, 9);
      syncPulse(12, 7);
      tag = "R8";
      invertOut = ~invertOut;
      syncPulse(5, 8);
      tag = "R7";
      syncPulse(1, 1);
      syncPulse(1, 1);
      syncPulse(1, 1);
      syncPulse(2, 1);
      syncPulse(1, 2);
      syncPulse(1, 8);
    end

    // R7: directed retrigger check, leading mode
    tag = "R7";
    doReset(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    syncPulse(1, 1);
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
    check(clampOut === 1'b1, "R7", int'(clampOut), 1);
    @(negedge clk);
    check(clampOut === 1'b1, "R7", int'(clampOut), 1);
    @(negedge clk);
    check(clampOut === 1'b0, "R7", int'(clampOut), 0);
    repeat (8) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule